// File: doc/BRIEF.md
# SPI Target with Select-Gated Transmit Load

This block is the target (slave) side of an 8-bit SPI link. An external controller drives the serial clock, the data-in line and an active-low select; the block answers on its data-out line. All three incoming lines are brought into the system clock domain through flop synchronizers. Clock edges are then found by comparing consecutive synchronized samples, so the serial clock must stay below one quarter of the system clock rate.

Local logic writes the next outgoing byte into a one-byte holding register, and a full flag shows that a byte is waiting. The byte moves into the shifter only while the target is selected and no byte is in progress. Each new assertion of select copies the holding register into the shifter again. When a byte completes, the received word is stored and a one-cycle interrupt pulse is raised. If select is released part-way through a byte, that byte is discarded without an interrupt, and the bit position starts again from zero on the next selection. Clock idle level and sampling phase are inputs that must match the controller's mode.

Top module: `spi_target`

## Requirements
- R1: After reset, `tx_full`, `rx_irq` and `miso_oe` are 0, `miso_out` is 1 and `rx_data` is 0x00.
- R2: Bytes are exchanged MSB first in all four modes. `sck_pol` is the idle level of the serial clock; the leading edge is the first edge away from idle. With `sck_pha`=0, bits are sampled on leading edges and the output changes on trailing edges. With `sck_pha`=1, the output changes on leading edges and bits are sampled on trailing edges.
- R3: A write while select is released leaves the byte in the holding register, with `tx_full`=1, until select is asserted. `tx_full` falls only while the target is selected.
- R4: Every assertion of select reloads the holding register into the shifter, even if that byte was already sent.
- R5: After the eighth sampled bit, `rx_data` takes the received byte and `rx_irq` is high for exactly one cycle. `rx_data` changes at no other time.
- R6: A write during a byte in progress keeps `tx_full`=1 until that byte has completed. The new byte then goes out as the next byte, with no reselection.
- R7: A second write while `tx_full`=1 replaces the pending byte, and only the latest byte is sent.
- R8: Releasing select before the eighth bit discards the partial byte: there is no `rx_irq`, `rx_data` keeps its value, and the bit count restarts at zero on the next selection.
- R9: While select is released, `miso_oe`=0 and `miso_out` is the idle level 1. While selected, `miso_oe`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sck_pol | input | 1 | Idle level of the serial clock |
| sck_pha | input | 1 | 0: sample on leading edge; 1: sample on trailing edge |
| sck_in | input | 1 | Serial clock from the controller (asynchronous) |
| mosi_in | input | 1 | Serial data from the controller (asynchronous) |
| sel_n_in | input | 1 | Active-low select from the controller (asynchronous) |
| miso_out | output | 1 | Serial data to the controller |
| miso_oe | output | 1 | Output enable for the data-out driver |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte to transmit |
| tx_full | output | 1 | Holding register has a byte not yet taken by the shifter |
| rx_data | output | 8 | Last completely received byte |
| rx_irq | output | 1 | One-cycle pulse when a byte completes |

## Verification
Full bytes are exchanged in each of the four clock modes, each with a different pattern in each direction. A phase or polarity swap, or an LSB-first order, therefore corrupts at least one of the compared bytes. Further cases separate the load rules from one another:
- a write while deselected, followed by selection;
- a write part-way through a byte, followed by back-to-back bytes;
- two writes before selection;
- reselection with no new write, which must resend the held byte.

A transfer cut off after five bits, followed by a full byte, shows whether a stray interrupt is raised and whether the bit count is left misaligned.

// File: rtl/spit_pkg.sv
// Shared types for the SPI target: the per-cycle event bundle that the
// edge decoder hands to the shifter and the top level.
package spit_pkg;

    typedef struct packed {
        logic sel_act;   // select asserted (synchronized)
        logic sel_fall;  // select became asserted this cycle
        logic lead;      // leading serial clock edge while selected
        logic trail;     // trailing serial clock edge while selected
        logic sample;    // capture a data-in bit this cycle
        logic drive;     // advance the data-out bit this cycle
        logic mosi;      // synchronized data-in level
    } spit_evt_t;

endpackage

// File: rtl/spit_sync.sv
// spit_sync: multi-stage flop synchronizer for a bundle of asynchronous
// single-bit inputs.
// Assumes STAGES >= 2 and that each bit is independent (no bus coherency).
module spit_sync #(
    parameter int              WIDTH   = 1,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    // Shift the raw inputs through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q <= {STAGES{RST_VAL}};
        else        stage_q <= {stage_q[STAGES-2:0], d};
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/spit_edges.sv
// spit_edges: finds serial clock and select edges in the system clock
// domain and maps them onto sample/drive strobes for the selected mode.
// Assumes its inputs are already synchronized and that the serial clock
// half period spans at least two system clocks.
module spit_edges
    import spit_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sck_pol,
    input  logic      sck_pha,
    input  logic      sck_s,
    input  logic      mosi_s,
    input  logic      sel_n_s,
    output spit_evt_t evt
);
    logic sck_q;
    logic sel_n_q;
    logic rise;
    logic fall;
    logic lead_raw;
    logic trail_raw;

    // Hold the previous synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q   <= 1'b0;
            sel_n_q <= 1'b1;
        end else begin
            sck_q   <= sck_s;
            sel_n_q <= sel_n_s;
        end
    end

    // Decode edges into the mode-dependent strobes.
    always_comb begin
        rise          = sck_s & ~sck_q;
        fall          = ~sck_s & sck_q;
        lead_raw      = sck_pol ? fall : rise;
        trail_raw     = sck_pol ? rise : fall;
        evt.sel_act   = ~sel_n_s;
        evt.sel_fall  = sel_n_q & ~sel_n_s;
        evt.lead      = lead_raw & ~sel_n_s;
        evt.trail     = trail_raw & ~sel_n_s;
        evt.sample    = sck_pha ? evt.trail : evt.lead;
        evt.drive     = sck_pha ? evt.lead : evt.trail;
        evt.mosi      = mosi_s;
    end
endmodule

// File: rtl/spit_shifter.sv
// spit_shifter: transmit and receive shift registers with the bit counter.
// Reports busy while a byte is under way (bit count non-zero or between a
// leading and trailing edge) so the load logic can wait for a clean point.
// Assumes the mode inputs stay constant while select is asserted.
module spit_shifter
    import spit_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_pha,
    input  spit_evt_t         evt,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rx_word,
    output logic              miso_bit
);
    localparam int CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    logic [DATA_W-1:0] tx_q;
    logic [DATA_W-1:0] rx_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              half_q;
    logic              out_q;

    // Byte is in progress between its first edge and its completion.
    assign busy     = (cnt_q != '0) | half_q | evt.lead;
    assign done     = evt.sample & (cnt_q == LAST);
    assign rx_word  = {rx_q[DATA_W-2:0], evt.mosi};
    assign miso_bit = sck_pha ? out_q : tx_q[DATA_W-1];

    // Transmit shifting and load from the holding register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q  <= '0;
            out_q <= 1'b0;
        end else if (load) begin
            tx_q  <= load_val;
            out_q <= load_val[DATA_W-1];
        end else if (evt.drive) begin
            tx_q  <= {tx_q[DATA_W-2:0], 1'b0};
            out_q <= tx_q[DATA_W-1];
        end
    end

    // Receive shifting, bit counting and the leading/trailing phase flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_q   <= '0;
            cnt_q  <= '0;
            half_q <= 1'b0;
        end else if (!evt.sel_act) begin
            cnt_q  <= '0;
            half_q <= 1'b0;
        end else begin
            if (evt.sample) begin
                rx_q  <= rx_word;
                cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
            end
            if (evt.lead)       half_q <= 1'b1;
            else if (evt.trail) half_q <= 1'b0;
        end
    end

    // R8
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !evt.sel_act |=> (cnt_q == '0));

    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == LAST) && evt.sample |=> (cnt_q == '0));
endmodule

// File: rtl/spi_target.sv
// spi_target: 8-bit SPI target with a one-byte transmit holding register
// and a receive register with a completion pulse.
// Assumes the serial clock runs below a quarter of clk and that sck_pol and
// sck_pha change only while select is released.
module spi_target
    import spit_pkg::*;
#(
    parameter int   DATA_W      = 8,
    parameter int   SYNC_STAGES = 2,
    parameter logic MISO_IDLE   = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_pol,
    input  logic              sck_pha,
    input  logic              sck_in,
    input  logic              mosi_in,
    input  logic              sel_n_in,
    output logic              miso_out,
    output logic              miso_oe,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              tx_full,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_irq
);
    localparam int SYNC_W = 3;

    logic [SYNC_W-1:0] pins_s;
    spit_evt_t         evt;
    logic [DATA_W-1:0] hold_q;
    logic              full_q;
    logic              load;
    logic              busy;
    logic              done;
    logic [DATA_W-1:0] rx_word;
    logic              miso_bit;
    logic [DATA_W-1:0] rx_q;
    logic              irq_q;

    spit_sync #(
        .WIDTH  (SYNC_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b100)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({sel_n_in, mosi_in, sck_in}),
        .q    (pins_s)
    );

    spit_edges u_edges (
        .clk    (clk),
        .rst_n  (rst_n),
        .sck_pol(sck_pol),
        .sck_pha(sck_pha),
        .sck_s  (pins_s[0]),
        .mosi_s (pins_s[1]),
        .sel_n_s(pins_s[2]),
        .evt    (evt)
    );

    spit_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .sck_pha (sck_pha),
        .evt     (evt),
        .load    (load),
        .load_val(hold_q),
        .busy    (busy),
        .done    (done),
        .rx_word (rx_word),
        .miso_bit(miso_bit)
    );

    // Shifter takes the held byte on every selection or when idle and pending.
    assign load = evt.sel_fall | (evt.sel_act & ~busy & full_q);

    // Holding register and its full flag; a write wins over a same-cycle load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
            full_q <= 1'b0;
        end else if (wr_en) begin
            hold_q <= wr_data;
            full_q <= 1'b1;
        end else if (load) begin
            full_q <= 1'b0;
        end
    end

    // Receive register and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_q  <= '0;
            irq_q <= 1'b0;
        end else begin
            irq_q <= done;
            if (done) rx_q <= rx_word;
        end
    end

    assign tx_full  = full_q;
    assign rx_data  = rx_q;
    assign rx_irq   = irq_q;
    assign miso_oe  = evt.sel_act;
    assign miso_out = evt.sel_act ? miso_bit : MISO_IDLE;

    // R5
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |=> !rx_irq);

    // R5
    rx_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_data) |-> rx_irq);

    // R3
    full_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_full) |-> $past(evt.sel_act));

    // R8
    irq_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> $past(evt.sel_act));
endmodule

// File: tb/spi_target_test.sv
// Scoreboard bench: the transfer task pushes expected received bytes,
// the monitor pops and compares them on every completion pulse.
module spi_target_test;
    localparam int H = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck_pol = 1'b0;
    logic       sck_pha = 1'b0;
    logic       sck_in = 1'b0;
    logic       mosi_in = 1'b0;
    logic       sel_n_in = 1'b1;
    logic       miso_out;
    logic       miso_oe;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       tx_full;
    logic [7:0] rx_data;
    logic       rx_irq;

    int         n_chk = 0;
    int         n_bad = 0;
    int         n_irq = 0;
    int         n_exp = 0;
    logic [7:0] exp_q [$];

    always #2 clk = ~clk;

    spi_target uut (
        .clk(clk), .rst_n(rst_n), .sck_pol(sck_pol), .sck_pha(sck_pha),
        .sck_in(sck_in), .mosi_in(mosi_in), .sel_n_in(sel_n_in),
        .miso_out(miso_out), .miso_oe(miso_oe), .wr_en(wr_en),
        .wr_data(wr_data), .tx_full(tx_full), .rx_data(rx_data),
        .rx_irq(rx_irq)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Monitor: compare every completed byte against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && rx_irq) begin
            n_irq++;
            if (exp_q.size() == 0) begin
                check(1'b0, "R8", "unexpected completion", rx_data, 0);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                check(rx_data == e, "R5", "received byte", rx_data, e);
            end
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_byte(input logic [7:0] b);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = b;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_mode(input logic pol, input logic pha);
        sck_pol = pol;
        sck_pha = pha;
        sck_in = pol;
        wait_clk(2 * H);
    endtask

    task automatic select();
        sel_n_in = 1'b0;
        wait_clk(2 * H);
    endtask

    task automatic deselect();
        sel_n_in = 1'b1;
        wait_clk(2 * H);
    endtask

    // Controller model: nbits clocks, optional write after bit wr_bit.
    task automatic xfer(input logic [7:0] mo, input logic [7:0] exp_mi,
                        input int nbits, input int wr_bit,
                        input logic [7:0] wr_val, input string req);
        logic [7:0] got;
        got = '0;
        if (nbits == 8) begin
            exp_q.push_back(mo);
            n_exp++;
        end
        for (int i = 0; i < nbits; i++) begin
            if (!sck_pha) begin
                mosi_in = mo[7-i];
                wait_clk(H);
                sck_in = ~sck_pol;
                got = {got[6:0], miso_out};
                wait_clk(H);
                sck_in = sck_pol;
            end else begin
                wait_clk(H);
                sck_in = ~sck_pol;
                mosi_in = mo[7-i];
                wait_clk(H);
                sck_in = sck_pol;
                got = {got[6:0], miso_out};
            end
            if (i == wr_bit) begin
                write_byte(wr_val);
                wait_clk(2);
                check(tx_full == 1'b1, "R6", "full during byte", tx_full, 1);
            end
        end
        wait_clk(H);
        if (nbits == 8)
            check(got == exp_mi, req, "bits sent MSB first", got, exp_mi);
    endtask

    initial begin
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(2);
        // R1 reset state
        check(tx_full == 1'b0, "R1", "tx_full", tx_full, 0);
        check(rx_irq == 1'b0, "R1", "rx_irq", rx_irq, 0);
        check(miso_oe == 1'b0, "R1", "miso_oe", miso_oe, 0);
        check(miso_out == 1'b1, "R1", "miso_out", miso_out, 1);
        check(rx_data == 8'h00, "R1", "rx_data", rx_data, 0);

        // Mode 0; R3 write while deselected
        set_mode(1'b0, 1'b0);
        write_byte(8'h3C);
        wait_clk(2 * H);
        check(tx_full == 1'b1, "R3", "held while deselected", tx_full, 1);
        check(miso_out == 1'b1, "R9", "idle level", miso_out, 1);
        check(miso_oe == 1'b0, "R9", "oe released", miso_oe, 0);
        select();
        check(tx_full == 1'b0, "R3", "taken on select", tx_full, 0);
        check(miso_oe == 1'b1, "R9", "oe when selected", miso_oe, 1);
        xfer(8'hA5, 8'h3C, 8, -1, 8'h00, "R2");
        deselect();

        // Modes 1, 2, 3 (R2)
        set_mode(1'b0, 1'b1);
        write_byte(8'h96);
        select();
        xfer(8'h5A, 8'h96, 8, -1, 8'h00, "R2");
        deselect();
        set_mode(1'b1, 1'b0);
        write_byte(8'hC3);
        select();
        xfer(8'h71, 8'hC3, 8, -1, 8'h00, "R2");
        deselect();
        set_mode(1'b1, 1'b1);
        write_byte(8'h0F);
        select();
        xfer(8'hE8, 8'h0F, 8, -1, 8'h00, "R2");
        deselect();

        // R7 overwrite while full
        set_mode(1'b0, 1'b0);
        write_byte(8'h11);
        write_byte(8'h22);
        check(tx_full == 1'b1, "R7", "full after two writes", tx_full, 1);
        select();
        xfer(8'h44, 8'h22, 8, -1, 8'h00, "R7");
        deselect();

        // R6 write during a byte, then back-to-back byte
        write_byte(8'h55);
        select();
        xfer(8'h18, 8'h55, 8, 3, 8'hC7, "R6");
        check(tx_full == 1'b0, "R6", "loaded after byte", tx_full, 0);
        xfer(8'h29, 8'hC7, 8, -1, 8'h00, "R6");
        deselect();

        // R4 reselect resends held byte (mode 1 this time)
        set_mode(1'b0, 1'b1);
        select();
        xfer(8'h3A, 8'hC7, 8, -1, 8'h00, "R4");
        deselect();

        // R8 abort after five bits
        set_mode(1'b0, 1'b0);
        select();
        xfer(8'hFF, 8'h00, 5, -1, 8'h00, "R8");
        deselect();
        check(rx_data == 8'h3A, "R8", "rx kept after abort", rx_data, 8'h3A);
        check(n_irq == n_exp, "R8", "no pulse on abort", n_irq, n_exp);
        select();
        xfer(8'h6B, 8'hC7, 8, -1, 8'h00, "R8");
        deselect();

        check(exp_q.size() == 0, "R5", "scoreboard drained", exp_q.size(), 0);
        check(n_irq == n_exp, "R5", "completion count", n_irq, n_exp);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule